// File: doc/BRIEF.md
# Line Latch with Dot-Inversion Polarity Steering

This block sits between a column-driver line loader and the per-channel converters. The loader presents a complete line of `NCH` codes, each `CW` bits wide, as one flat parallel bus. A line strobe `lstb` marks each transfer. The block detects the strobe's edges inside the `clk` domain. On the rising edge it copies the whole line into a holding stage, samples the line polarity input, and sends the loader a one-cycle clear pulse so that the loader's token chain restarts. On the falling edge it moves the held codes onto the channel outputs and raises the output enable.

Each channel also gets a reference-select bit. A 1 selects the upper reference set and a 0 selects the lower set. Neighbouring channels always get opposite selects, which gives dot inversion. The polarity sampled at the rising edge decides which parity gets the upper set. The select bits change only on the falling edge, in the same cycle as the codes.

The line bus has no valid/ready pair and never applies back-pressure. The strobe alone qualifies the data, and the loader must hold the line steady on the clock edge where the strobe is first seen high. Between strobes the bus is ignored.

Top module: `sll_line_latch`

## Requirements
- R1: While reset is active and after reset, until the first strobe falling edge: `out_en` is 0, every code on `chan_code` is 0, `ref_upper` is all 0 and `ldr_clr` is 0.
- R2: `ldr_clr` goes high for exactly one cycle, in the cycle after the clock edge that first sees `lstb` high.
- R3: `line_code` is captured only at the clock edge that first sees `lstb` high. Changes to `line_code` while the strobe stays high, or while it is low, do not reach the outputs.
- R4: The codes from the last capture appear on `chan_code` after the clock edge that first sees `lstb` low. From then on `out_en` is 1.
- R5: `chan_code`, `ref_upper` and `out_en` change only after a strobe falling edge. A rising edge alone leaves them unchanged.
- R6: Channel i sits at bits [i*CW +: CW], counting channels from 0. When the sampled polarity is 1, channels with even i (odd-numbered channels counted from 1) get `ref_upper[i]`=1 and channels with odd i get 0. When the polarity is 0 the assignment is swapped. After the first release, adjacent bits always differ.
- R7: `pol` is sampled only at the strobe rising edge. A change of `pol` between the rise and the fall does not affect `ref_upper`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_code | input | NCH*CW | Loaded line, channel i at bits [i*CW +: CW] |
| lstb | input | 1 | Line-latch strobe (level; both edges act) |
| pol | input | 1 | Line polarity, sampled at strobe rise |
| ldr_clr | output | 1 | One-cycle clear pulse to the loader tokens |
| chan_code | output | NCH*CW | Released per-channel codes |
| ref_upper | output | NCH | Per-channel reference select, 1 = upper set |
| out_en | output | 1 | Output enable, high after first release |

## Verification
The first clock edge that sees the strobe high samples the line and the polarity. `ldr_clr` is then read at the next falling clock edge and must be back low one cycle later. Codes and selects are due one clock after the edge that first sees the strobe low. A monitor recomputes that edge from the strobe it drives, then pops the expected line from the scoreboard and compares at the following falling edge. While the strobe is held high, the driver changes the line and the polarity, then confirms that the outputs still show the previous release.

// File: rtl/sll_pkg.sv
package sll_pkg;
  // Upper-reference select for channel index idx (0-based) under line polarity p.
  function automatic logic upper_sel(input logic p, input int unsigned idx);
    return p ^ idx[0];
  endfunction
endpackage

// File: rtl/sll_edge.sv
module sll_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/sll_chan.sv
module sll_chan #(
  parameter int unsigned CW  = 6,
  parameter int unsigned IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          rel,
  input  logic          pol_held,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] dout,
  output logic          sel
);
  import sll_pkg::*;

  logic [CW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      dout   <= '0;
      sel    <= 1'b0;
    end else begin
      if (cap) hold_q <= din;
      if (rel) begin
        dout <= hold_q;
        sel  <= upper_sel(pol_held, IDX);
      end
    end
  end
endmodule

// File: rtl/sll_line_latch.sv
module sll_line_latch #(
  parameter int unsigned NCH = 420,
  parameter int unsigned CW  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH*CW-1:0]   line_code,
  input  logic                lstb,
  input  logic                pol,
  output logic                ldr_clr,
  output logic [NCH*CW-1:0]   chan_code,
  output logic [NCH-1:0]      ref_upper,
  output logic                out_en
);
  localparam int unsigned BUS_W = NCH * CW;

  logic stb_rise, stb_fall;
  logic pol_q;

  sll_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (lstb),
    .rise (stb_rise),
    .fall (stb_fall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q   <= 1'b0;
      ldr_clr <= 1'b0;
      out_en  <= 1'b0;
    end else begin
      ldr_clr <= stb_rise;
      if (stb_rise) pol_q  <= pol;
      if (stb_fall) out_en <= 1'b1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    sll_chan #(.CW(CW), .IDX(i)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (stb_rise),
      .rel     (stb_fall),
      .pol_held(pol_q),
      .din     (line_code[i*CW +: CW]),
      .dout    (chan_code[i*CW +: CW]),
      .sel     (ref_upper[i])
    );
  end

  logic unused_ok;
  assign unused_ok = ^BUS_W;
endmodule

// File: rtl/sll_line_latch_chk.sv
module sll_line_latch_chk #(
  parameter int unsigned NCH = 420,
  parameter int unsigned CW  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lstb,
  input logic              ldr_clr,
  input logic [NCH*CW-1:0] chan_code,
  input logic [NCH-1:0]    ref_upper,
  input logic              out_en
);
  logic prev_stb;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_stb <= 1'b0;
    else        prev_stb <= lstb;
  end

  logic saw_rise, saw_fall;
  assign saw_rise = lstb & ~prev_stb;
  assign saw_fall = ~lstb & prev_stb;

  logic alt_ok;
  assign alt_ok = &(ref_upper[NCH-1:1] ^ ref_upper[NCH-2:0]);

  p_clr_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    saw_rise |=> ldr_clr);
  p_clr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ldr_clr |=> !ldr_clr);
  p_en_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    saw_fall |=> out_en);
  p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !saw_fall |=> ($stable(chan_code) && $stable(ref_upper) && $stable(out_en)));
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (chan_code == '0 && ref_upper == '0));
  p_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> alt_ok);
endmodule

bind sll_line_latch sll_line_latch_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lstb     (lstb),
  .ldr_clr  (ldr_clr),
  .chan_code(chan_code),
  .ref_upper(ref_upper),
  .out_en   (out_en)
);

// File: tb/test_sll_line_latch.sv
module test_sll_line_latch;
  localparam int unsigned NCH   = 420;
  localparam int unsigned CW    = 6;
  localparam int unsigned BUS_W = NCH * CW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [BUS_W-1:0] line_code = '0;
  logic             lstb = 1'b0;
  logic             pol = 1'b0;
  logic             ldr_clr;
  logic [BUS_W-1:0] chan_code;
  logic [NCH-1:0]   ref_upper;
  logic             out_en;

  always #5 clk = ~clk;

  sll_line_latch #(.NCH(NCH), .CW(CW)) i_sll_line_latch (
    .clk(clk), .rst_n(rst_n), .line_code(line_code), .lstb(lstb), .pol(pol),
    .ldr_clr(ldr_clr), .chan_code(chan_code), .ref_upper(ref_upper), .out_en(out_en)
  );

  int checks = 0;
  int fails  = 0;
  logic [BUS_W-1:0] exp_code_q[$];
  logic [NCH-1:0]   exp_sel_q[$];
  logic [BUS_W-1:0] last_code = '0;
  logic [NCH-1:0]   last_sel  = '0;
  logic             last_en   = 1'b0;

  task automatic check(input string req, input logic [BUS_W-1:0] act,
                       input logic [BUS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] make_line(input int seed);
    logic [BUS_W-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*CW +: CW] = CW'((i * seed + seed * 7 + 3) % 64);
    return v;
  endfunction

  function automatic logic [NCH-1:0] make_sel(input logic p);
    logic [NCH-1:0] s;
    for (int i = 0; i < NCH; i++) s[i] = p ^ i[0];
    return s;
  endfunction

  // Driver: one strobe pulse, with tampering while strobe is high (R3, R7)
  task automatic drive_line(input logic [BUS_W-1:0] v, input logic p);
    @(negedge clk);
    line_code = v; pol = p; lstb = 1'b1;
    exp_code_q.push_back(v);
    exp_sel_q.push_back(make_sel(p));
    @(negedge clk);
    check("R2 clr pulse high", BUS_W'(ldr_clr), BUS_W'(1));
    check("R5 codes held on rise", chan_code, last_code);
    line_code = ~v; pol = ~p;
    @(negedge clk);
    check("R2 clr pulse one cycle", BUS_W'(ldr_clr), BUS_W'(0));
    line_code = make_line(99);
    @(negedge clk);
    check("R5 sel held on rise", BUS_W'(ref_upper), BUS_W'(last_sel));
    check("R5 en held on rise", BUS_W'(out_en), BUS_W'(last_en));
    lstb = 1'b0;
    last_code = v; last_sel = make_sel(p); last_en = 1'b1;
    repeat (3) @(negedge clk);
    line_code = make_line(55); pol = ~pol;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: finds the strobe fall edge and compares one clock later
  initial begin
    logic prev = 1'b0;
    forever begin
      logic f;
      @(posedge clk);
      f = rst_n && !lstb && prev;
      prev = rst_n ? lstb : 1'b0;
      if (f) begin
        @(negedge clk);
        if (exp_code_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R4 release with empty scoreboard actual=%h expected=none", chan_code);
        end else begin
          logic [BUS_W-1:0] ec;
          logic [NCH-1:0]   es;
          ec = exp_code_q.pop_front();
          es = exp_sel_q.pop_front();
          check("R3 R4 released codes", chan_code, ec);
          check("R6 R7 reference select", BUS_W'(ref_upper), BUS_W'(es));
          check("R4 out_en high", BUS_W'(out_en), BUS_W'(1));
        end
      end
    end
  end

  initial begin
    #(10 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out_en", BUS_W'(out_en), BUS_W'(0));
    check("R1 reset codes", chan_code, '0);
    rst_n = 1'b1;
    line_code = make_line(5);
    repeat (2) @(negedge clk);
    check("R1 idle codes", chan_code, '0);
    check("R1 idle sel", BUS_W'(ref_upper), BUS_W'(0));
    check("R1 idle clr", BUS_W'(ldr_clr), BUS_W'(0));
    check("R1 idle en", BUS_W'(out_en), BUS_W'(0));
    drive_line(make_line(3), 1'b1);
    drive_line(make_line(11), 1'b0);
    drive_line({BUS_W{1'b1}}, 1'b1);
    drive_line('0, 1'b0);
    drive_line(make_line(29), 1'b0);
    repeat (3) @(negedge clk);
    check("R5 final hold", chan_code, last_code);
    check("R4 scoreboard drained", BUS_W'(exp_code_q.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule